// File: doc/BRIEF.md
# Dual-Port Sample Stream Demultiplexer

This block sits behind a sampling converter core. On every rising edge of the encode clock it takes one code, together with flags that say the input was above or below full scale. It saturates and formats that code, then sends consecutive samples to two output ports in turn, so each port carries every other sample at half the encode rate. A half-rate data clock, taken from the same encode clock, rises on every edge that loads port B, so downstream logic can latch both ports with it.

A sync input fixes which sample goes to which port and can stop the outputs. While sync is high the ports and the data clock do not change. A high-to-low transition of sync sends that sample to port B and the next sample to port A. A mode pin selects interleaved timing, where the ports update on alternate encode edges, or parallel timing. In parallel timing port A is delayed by one more stage, so both ports update on the same edge. A format pin selects offset-binary or two's-complement output.

Top module: `adc_dual_port_demux`

## Requirements
- R1: On an encode edge with `rst` high, both port codes and both port flags go to zero and `dclk_out` goes low. They stay there until the first sample is loaded into port B.
- R2: Samples accepted on consecutive encode edges go to opposite ports, B and A in turn. Each port is loaded at most once every two encode edges.
- R3: The first sample after a sync falling edge goes to port B, and the next sample goes to port A. A falling edge is `sync_in` high at one edge and low at the next. After reset is released with `sync_in` low, the first sample also goes to port B.
- R4: In interleaved timing a sample taken at edge E appears on its port right after edge E+6, on either port. The two ports never change on the same edge.
- R5: In parallel timing a sample for port B appears after edge E+6 and a sample for port A appears after edge E+7. The A and B loads then fall on the same edges.
- R6: `ilv_mode` = 1 selects interleaved timing and `ilv_mode` = 0 selects parallel timing.
- R7: On any encode edge where `sync_in` is high, the port codes, the port flags and `dclk_out` keep their values. The sample taken on that edge is discarded.
- R8: With `fmt_tc` = 0 the port code is the offset-binary input code. With `fmt_tc` = 1 it is the same code with its MSB (bit W-1) inverted. The format pin is sampled together with the sample.
- R9: When `samp_over` is set, the code becomes the maximum: all ones in offset binary, or 0x1FF (01_1111_1111) in two's complement for W=10. The flag of the port that receives the sample is set.
- R10: When `samp_under` is set and `samp_over` is clear, the code becomes the minimum: all zeros in offset binary, or 0x200 for W=10. The port flag is set. A sample with neither flag clears the port flag when it is loaded.
- R11: `dclk_out` goes high on each edge that loads port B. On every other edge that is not frozen, it inverts, once the first port-B load has happened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encode clock; every register uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| samp_code | input | W | Converter code, offset binary |
| samp_over | input | 1 | Input was above positive full scale |
| samp_under | input | 1 | Input was below negative full scale |
| sync_in | input | 1 | Sync: high freezes the outputs, a falling edge steers the next sample to port B |
| ilv_mode | input | 1 | 1 = interleaved timing, 0 = parallel timing |
| fmt_tc | input | 1 | 1 = two's complement, 0 = offset binary |
| porta_data | output | W | Port A code |
| porta_ovr | output | 1 | Port A out-of-range flag |
| portb_data | output | W | Port B code |
| portb_ovr | output | 1 | Port B out-of-range flag |
| dclk_out | output | 1 | Half-rate data clock |

## Verification
The main checks use ramps, where every sample is distinct, so a wrong port, a wrong latency or a lost sample each shows up as a specific wrong code in a specific cycle. The ramps run in both timing modes, two kinds of start are applied, and a five-cycle sync-high window is inserted mid-stream:
- Starting with sync held high and then dropped checks steering after a sync falling edge.
- Starting with sync low from reset checks steering after reset release.
- The sync-high window shows whether the outputs freeze and whether the following sync realigns the data clock.

A table of constant codes with the range flags and the format pin checks saturation, the precedence between the two flags, the MSB inversion, and the clearing of the port flag.

// File: rtl/adcdmx_pkg.sv
package adcdmx_pkg;
   typedef enum logic {
      PORT_A = 1'b0,
      PORT_B = 1'b1
   } adcdmx_port_e;
endpackage

// File: rtl/adcdmx_code_map.sv
module adcdmx_code_map #(
   parameter int unsigned W = 10
) (
   input  logic [W-1:0] raw_code,
   input  logic         raw_over,
   input  logic         raw_under,
   input  logic         fmt_tc,
   output logic [W-1:0] out_code,
   output logic         out_ovr
);
   localparam logic [W-1:0] CODE_MAX = {W{1'b1}};
   localparam logic [W-1:0] CODE_MIN = {W{1'b0}};

   logic [W-1:0] sat_code;

   always_comb begin
      if (raw_over)       sat_code = CODE_MAX;
      else if (raw_under) sat_code = CODE_MIN;
      else                sat_code = raw_code;
      out_code = sat_code;
      if (fmt_tc) out_code[W-1] = ~sat_code[W-1];
      out_ovr = raw_over | raw_under;
   end
endmodule

// File: rtl/adcdmx_sync_ctl.sv
module adcdmx_sync_ctl
   import adcdmx_pkg::*;
(
   input  logic         clk,
   input  logic         rst,
   input  logic         sync_in,
   output adcdmx_port_e cur_port,
   output logic         cur_valid
);
   logic         sync_q;
   adcdmx_port_e port_q;
   logic         sync_fall;

   assign sync_fall = sync_q & ~sync_in;
   assign cur_port  = sync_fall ? PORT_B : ((port_q == PORT_A) ? PORT_B : PORT_A);
   assign cur_valid = ~sync_in;

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_q <= 1'b0;
         port_q <= PORT_A;
      end else begin
         sync_q <= sync_in;
         port_q <= cur_port;
      end
   end
endmodule

// File: rtl/adcdmx_delay_line.sv
module adcdmx_delay_line
   import adcdmx_pkg::*;
#(
   parameter int unsigned W     = 10,
   parameter int unsigned DEPTH = 7
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] in_code,
   input  logic         in_ovr,
   input  adcdmx_port_e in_port,
   input  logic         in_valid,
   output logic [W-1:0] tapn_code,
   output logic         tapn_ovr,
   output adcdmx_port_e tapn_port,
   output logic         tapn_valid,
   output logic [W-1:0] tapl_code,
   output logic         tapl_ovr,
   output adcdmx_port_e tapl_port,
   output logic         tapl_valid
);
   localparam int unsigned NEAR = DEPTH - 1;

   logic [W-1:0] st_code  [1:DEPTH];
   logic         st_ovr   [1:DEPTH];
   adcdmx_port_e st_port  [1:DEPTH];
   logic         st_valid [1:DEPTH];

   for (genvar g = 1; g <= DEPTH; g++) begin : g_stage
      if (g == 1) begin : g_head
         always_ff @(posedge clk) begin
            if (rst) st_valid[g] <= 1'b0;
            else     st_valid[g] <= in_valid;
            st_code[g] <= in_code;
            st_ovr[g]  <= in_ovr;
            st_port[g] <= in_port;
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (rst) st_valid[g] <= 1'b0;
            else     st_valid[g] <= st_valid[g-1];
            st_code[g] <= st_code[g-1];
            st_ovr[g]  <= st_ovr[g-1];
            st_port[g] <= st_port[g-1];
         end
      end
   end

   assign tapn_code  = st_code[NEAR];
   assign tapn_ovr   = st_ovr[NEAR];
   assign tapn_port  = st_port[NEAR];
   assign tapn_valid = st_valid[NEAR];
   assign tapl_code  = st_code[DEPTH];
   assign tapl_ovr   = st_ovr[DEPTH];
   assign tapl_port  = st_port[DEPTH];
   assign tapl_valid = st_valid[DEPTH];
endmodule

// File: rtl/adcdmx_port_out.sv
module adcdmx_port_out
   import adcdmx_pkg::*;
#(
   parameter int unsigned W = 10
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         hold,
   input  logic         ilv_mode,
   input  logic [W-1:0] tapn_code,
   input  logic         tapn_ovr,
   input  adcdmx_port_e tapn_port,
   input  logic         tapn_valid,
   input  logic [W-1:0] tapl_code,
   input  logic         tapl_ovr,
   input  adcdmx_port_e tapl_port,
   input  logic         tapl_valid,
   output logic [W-1:0] porta_data,
   output logic         porta_ovr,
   output logic [W-1:0] portb_data,
   output logic         portb_ovr,
   output logic         dclk_out
);
   logic [W-1:0] a_code;
   logic         a_ovr;
   logic         a_load;
   logic         b_load;
   logic         clk_run;

   always_comb begin
      if (ilv_mode) begin
         a_code = tapn_code;
         a_ovr  = tapn_ovr;
         a_load = tapn_valid && (tapn_port == PORT_A);
      end else begin
         a_code = tapl_code;
         a_ovr  = tapl_ovr;
         a_load = tapl_valid && (tapl_port == PORT_A);
      end
      b_load = tapn_valid && (tapn_port == PORT_B);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         porta_data <= '0;
         porta_ovr  <= 1'b0;
         portb_data <= '0;
         portb_ovr  <= 1'b0;
         dclk_out   <= 1'b0;
         clk_run    <= 1'b0;
      end else if (!hold) begin
         if (a_load) begin
            porta_data <= a_code;
            porta_ovr  <= a_ovr;
         end
         if (b_load) begin
            portb_data <= tapn_code;
            portb_ovr  <= tapn_ovr;
         end
         if (b_load)       dclk_out <= 1'b1;
         else if (clk_run) dclk_out <= ~dclk_out;
         clk_run <= clk_run | b_load;
      end
   end
endmodule

// File: rtl/adc_dual_port_demux.sv
module adc_dual_port_demux
   import adcdmx_pkg::*;
#(
   parameter int unsigned W   = 10,
   parameter int unsigned LAT = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] samp_code,
   input  logic         samp_over,
   input  logic         samp_under,
   input  logic         sync_in,
   input  logic         ilv_mode,
   input  logic         fmt_tc,
   output logic [W-1:0] porta_data,
   output logic         porta_ovr,
   output logic [W-1:0] portb_data,
   output logic         portb_ovr,
   output logic         dclk_out
);
   localparam int unsigned DEPTH = LAT + 1;

   if (W < 2) begin : g_bad_width
      $error("adc_dual_port_demux: W must be at least 2");
   end
   if (LAT < 2) begin : g_bad_latency
      $error("adc_dual_port_demux: LAT must be at least 2");
   end

   logic [W-1:0] map_code;
   logic         map_ovr;
   adcdmx_port_e cur_port;
   logic         cur_valid;
   logic [W-1:0] tapn_code, tapl_code;
   logic         tapn_ovr, tapl_ovr;
   adcdmx_port_e tapn_port, tapl_port;
   logic         tapn_valid, tapl_valid;

   adcdmx_code_map #(.W(W)) u_map (
      .raw_code (samp_code),
      .raw_over (samp_over),
      .raw_under(samp_under),
      .fmt_tc   (fmt_tc),
      .out_code (map_code),
      .out_ovr  (map_ovr)
   );

   adcdmx_sync_ctl u_sync (
      .clk      (clk),
      .rst      (rst),
      .sync_in  (sync_in),
      .cur_port (cur_port),
      .cur_valid(cur_valid)
   );

   adcdmx_delay_line #(.W(W), .DEPTH(DEPTH)) u_dly (
      .clk       (clk),
      .rst       (rst),
      .in_code   (map_code),
      .in_ovr    (map_ovr),
      .in_port   (cur_port),
      .in_valid  (cur_valid),
      .tapn_code (tapn_code),
      .tapn_ovr  (tapn_ovr),
      .tapn_port (tapn_port),
      .tapn_valid(tapn_valid),
      .tapl_code (tapl_code),
      .tapl_ovr  (tapl_ovr),
      .tapl_port (tapl_port),
      .tapl_valid(tapl_valid)
   );

   adcdmx_port_out #(.W(W)) u_out (
      .clk       (clk),
      .rst       (rst),
      .hold      (sync_in),
      .ilv_mode  (ilv_mode),
      .tapn_code (tapn_code),
      .tapn_ovr  (tapn_ovr),
      .tapn_port (tapn_port),
      .tapn_valid(tapn_valid),
      .tapl_code (tapl_code),
      .tapl_ovr  (tapl_ovr),
      .tapl_port (tapl_port),
      .tapl_valid(tapl_valid),
      .porta_data(porta_data),
      .porta_ovr (porta_ovr),
      .portb_data(portb_data),
      .portb_ovr (portb_ovr),
      .dclk_out  (dclk_out)
   );
endmodule

// File: rtl/adcdmx_checker.sv
module adcdmx_checker #(
   parameter int unsigned W = 10
) (
   input logic         clk,
   input logic         rst,
   input logic         sync_in,
   input logic         ilv_mode,
   input logic [W-1:0] porta_data,
   input logic         porta_ovr,
   input logic [W-1:0] portb_data,
   input logic         portb_ovr,
   input logic         dclk_out
);
   localparam logic [W-1:0] OB_MAX = {W{1'b1}};
   localparam logic [W-1:0] OB_MIN = {W{1'b0}};
   localparam logic [W-1:0] TC_MAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] TC_MIN = {1'b1, {(W-1){1'b0}}};

   logic rst_seen = 1'b0;
   always_ff @(posedge clk) rst_seen <= rst;

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst_seen |-> (porta_data == '0 && portb_data == '0 && !porta_ovr && !portb_ovr && !dclk_out));

   assert_freeze_hold_R7: assert property (@(posedge clk) disable iff (rst)
      sync_in |=> ($stable(porta_data) && $stable(portb_data) && $stable(dclk_out)
                   && $stable(porta_ovr) && $stable(portb_ovr)));

   assert_ilv_alternate_R4: assert property (@(posedge clk) disable iff (rst)
      (!rst_seen && $past(ilv_mode) && !$stable(porta_data)) |-> $stable(portb_data));

   assert_dclk_on_b_load_R11: assert property (@(posedge clk) disable iff (rst)
      (!rst_seen && !$stable(portb_data)) |-> dclk_out);

   // R9 and R10: a raised flag always comes with a saturated code
   assert_ovr_extreme_R9: assert property (@(posedge clk) disable iff (rst)
      porta_ovr |-> (porta_data == OB_MAX || porta_data == OB_MIN ||
                     porta_data == TC_MAX || porta_data == TC_MIN));

   assert_ovr_extreme_R10: assert property (@(posedge clk) disable iff (rst)
      portb_ovr |-> (portb_data == OB_MAX || portb_data == OB_MIN ||
                     portb_data == TC_MAX || portb_data == TC_MIN));
endmodule

bind adc_dual_port_demux adcdmx_checker #(.W(W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .sync_in   (sync_in),
   .ilv_mode  (ilv_mode),
   .porta_data(porta_data),
   .porta_ovr (porta_ovr),
   .portb_data(portb_data),
   .portb_ovr (portb_ovr),
   .dclk_out  (dclk_out)
);

// File: tb/sim_adc_dual_port_demux.sv
module sim_adc_dual_port_demux;
   localparam int W = 10;
   localparam int NVEC = 11;
   // {raw, over, under, fmt_tc, expected code, expected flag}
   localparam logic [23:0] VEC [NVEC] = '{
      {10'h1A5, 1'b0, 1'b0, 1'b0, 10'h1A5, 1'b0},
      {10'h1A5, 1'b0, 1'b0, 1'b1, 10'h3A5, 1'b0},
      {10'h200, 1'b0, 1'b0, 1'b1, 10'h000, 1'b0},
      {10'h3FF, 1'b0, 1'b0, 1'b1, 10'h1FF, 1'b0},
      {10'h000, 1'b0, 1'b0, 1'b1, 10'h200, 1'b0},
      {10'h123, 1'b1, 1'b0, 1'b0, 10'h3FF, 1'b1},
      {10'h123, 1'b1, 1'b0, 1'b1, 10'h1FF, 1'b1},
      {10'h321, 1'b0, 1'b1, 1'b0, 10'h000, 1'b1},
      {10'h321, 1'b0, 1'b1, 1'b1, 10'h200, 1'b1},
      {10'h0F0, 1'b1, 1'b1, 1'b0, 10'h3FF, 1'b1},
      {10'h2AA, 1'b0, 1'b0, 1'b0, 10'h2AA, 1'b0}
   };

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] samp_code = '0;
   logic         samp_over = 1'b0;
   logic         samp_under = 1'b0;
   logic         sync_in = 1'b1;
   logic         ilv_mode = 1'b1;
   logic         fmt_tc = 1'b0;
   logic [W-1:0] porta_data, portb_data;
   logic         porta_ovr, portb_ovr, dclk_out;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   adc_dual_port_demux #(.W(W), .LAT(6)) u0 (
      .clk(clk), .rst(rst), .samp_code(samp_code), .samp_over(samp_over),
      .samp_under(samp_under), .sync_in(sync_in), .ilv_mode(ilv_mode),
      .fmt_tc(fmt_tc), .porta_data(porta_data), .porta_ovr(porta_ovr),
      .portb_data(portb_data), .portb_ovr(portb_ovr), .dclk_out(dclk_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit sync_pat(input int pat, input int j);
      case (pat)
         0:       return j < 3;
         1:       return (j < 3) || (j >= 20 && j < 25);
         default: return 1'b0;
      endcase
   endfunction

   // Ramp stream with a reference model built from the requirements
   task automatic run_stream(input bit ilv, input int pat, input int base);
      bit mval [64];
      bit mtag [64];
      logic [W-1:0] exp_a = '0, exp_b = '0;
      bit exp_d = 0, run = 0, sprev = 0, tprev = 0, froze = 0;
      @(negedge clk);
      rst = 1'b1; sync_in = 1'b1; ilv_mode = ilv; fmt_tc = 1'b0;
      samp_over = 1'b0; samp_under = 1'b0;
      for (int j = 0; j < 40; j++) begin
         @(negedge clk);
         if (j == 0) begin
            chk("R1 reset porta", porta_data, 0);
            chk("R1 reset portb", portb_data, 0);
            chk("R1 reset flags", {porta_ovr, portb_ovr}, 0);
            chk("R1 reset dclk", dclk_out, 0);
         end else begin
            chk(froze ? "R7 porta held" : (ilv ? "R4 R6 porta" : "R5 R6 porta"), porta_data, exp_a);
            chk(froze ? "R7 portb held" : "R2 R3 portb", portb_data, exp_b);
            chk(froze ? "R7 dclk held" : "R11 dclk", dclk_out, exp_d);
         end
         rst = 1'b0;
         sync_in = sync_pat(pat, j);
         samp_code = W'(base + j);
         begin
            bit sj, tg, bl, al;
            int src;
            sj = sync_pat(pat, j);
            tg = (sprev && !sj) ? 1'b1 : !tprev;
            mval[j] = !sj; mtag[j] = tg;
            sprev = sj; tprev = tg; froze = sj;
            if (!sj) begin
               bl  = (j >= 6) && mval[j-6] && mtag[j-6];
               src = ilv ? j - 6 : j - 7;
               al  = (src >= 0) && mval[src] && !mtag[src];
               if (bl) exp_b = W'(base + j - 6);
               if (al) exp_a = W'(base + src);
               if (bl) exp_d = 1'b1;
               else if (run) exp_d = !exp_d;
               run = run | bl;
            end
         end
      end
   endtask

   initial begin
      run_stream(1'b1, 0, 200);
      run_stream(1'b0, 0, 300);
      run_stream(1'b1, 1, 400);
      run_stream(1'b0, 1, 500);
      run_stream(1'b1, 2, 600);
      run_stream(1'b0, 2, 700);

      // Coding table: hold each vector long enough to reach both ports
      @(negedge clk);
      rst = 1'b1; sync_in = 1'b0; ilv_mode = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int v = 0; v < NVEC; v++) begin
         samp_code  = VEC[v][23:14];
         samp_over  = VEC[v][13];
         samp_under = VEC[v][12];
         fmt_tc     = VEC[v][11];
         repeat (8) @(negedge clk);
         chk("R8 R9 R10 porta code", porta_data, VEC[v][10:1]);
         chk("R8 R9 R10 portb code", portb_data, VEC[v][10:1]);
         chk("R9 R10 porta flag", porta_ovr, VEC[v][0]);
         chk("R9 R10 portb flag", portb_ovr, VEC[v][0]);
      end

      // Reset in the middle of saturated traffic
      samp_over = 1'b1;
      repeat (8) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk("R1 mid-run porta", {porta_ovr, porta_data}, 0);
      chk("R1 mid-run portb", {portb_ovr, portb_data}, 0);
      chk("R1 mid-run dclk", dclk_out, 0);
      rst = 1'b0; sync_in = 1'b1;
      repeat (10) @(negedge clk);
      chk("R1 R7 held after reset", {dclk_out, portb_ovr, portb_data}, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule